// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache

This block is a read-only cache that sits between a processor request port and a slower word-wide backing memory. Each line holds one 32-bit word. A byte address is split into a set index and a tag. The index picks one of 256 sets, and the tag is compared against all four ways of that set at once. When a valid way matches, the stored word comes back on the next cycle without touching memory.

When no way matches, the block stalls the processor port and issues a single word request to memory. When memory acknowledges, the returned word is written into a victim way and is also forwarded to the processor. The victim is chosen as follows: an empty way in the set is used first. If all four ways are valid, the way that has gone unused the longest is evicted. Every set keeps its own recency order as four 2-bit ages.

Top module: `sa_cache`

## Requirements
- R1: After a synchronous active-high reset, every way is invalid, `cpu_ready` is 1, and both `cpu_rvalid` and `mem_req` are 0.
- R2: The set index is address bits [9:2] and the tag is bits [31:10]. Bits [1:0] take no part in the lookup, so two addresses that differ only there hit the same word. Two addresses with the same index and different tags occupy separate ways.
- R3: A request accepted while `cpu_ready` is 1 that hits returns `cpu_rvalid`=1 with the stored word in the cycle after the accepting edge, and does not raise `mem_req`.
- R4: A request that misses causes `mem_req`=1 and `cpu_ready`=0 from the cycle after the accepting edge. `mem_addr` equals the request address, and both stay unchanged until the edge at which `mem_ack` is 1.
- R5: In the cycle after the `mem_ack` edge, `cpu_rvalid` is 1 with `cpu_rdata` equal to the `mem_rdata` sampled at that edge, `cpu_ready` returns to 1, and a later request to the same word hits.
- R6: Within a set, an invalid way is filled before any valid way is evicted, so four distinct tags in one set all remain resident.
- R7: With all four ways valid, a miss replaces the least recently used way. Both hits and fills make a way the most recent.
- R8: Word requests to block addresses 0, 8, 0, 6, 8 (byte addresses 0, 32, 0, 24, 32) from reset give exactly 3 misses.
- R9: `cpu_req` is ignored while `cpu_ready` is 0. It does not change `mem_addr` and produces no extra response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor read request, taken when cpu_ready is 1 |
| cpu_addr | input | 32 | Processor byte address |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_rvalid | output | 1 | Read data valid this cycle |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | Word fetch request to backing memory |
| mem_addr | output | 32 | Fetch byte address |
| mem_ack | input | 1 | Memory returns data this cycle |
| mem_rdata | input | 32 | Data returned by memory |

## Verification
A hit is due at the first sample after the edge that takes the request. A miss shows `mem_req` and the fetch address at that same sample, and its data is due at the first sample after the edge where `mem_ack` is high. The bench drives and samples on the falling edge, so each check falls on exactly the cycle in which the result becomes due. A behavioural model with timestamps predicts hit or miss for every request and the word it should return. Waits with varying memory latency and requests injected during a stall check that nothing appears early or extra.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int WAYS   = 4;
    localparam int SETS   = 256;
    localparam int OFF_W  = $clog2(DATA_W / 8);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int AGE_W  = $clog2(WAYS);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
    } tag_entry_t;

    typedef enum logic {ST_IDLE, ST_FILL} cst_e;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction
endpackage

// File: rtl/cache_way_match.sv
module cache_way_match
    import cache_pkg::*;
#(
    parameter int N = WAYS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tag_entry_t [N-1:0]   ways_i,
    input  logic [TAG_W-1:0]     tag_i,
    input  logic [N-1:0]         oldest_i,
    output logic                 hit_o,
    output logic [WAY_W-1:0]     hit_way_o,
    output logic [WAY_W-1:0]     victim_o
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = ways_i[g].valid && (ways_i[g].tag == tag_i);
    end

    assign hit_o = |hit_vec;

    always_comb begin
        hit_way_o = '0;
        for (int i = N - 1; i >= 0; i--)
            if (hit_vec[i]) hit_way_o = WAY_W'(i);
    end

    // Empty way wins; otherwise the oldest way.
    always_comb begin
        logic found;
        found    = 1'b0;
        victim_o = '0;
        for (int i = 0; i < N; i++)
            if (!found && !ways_i[i].valid) begin
                victim_o = WAY_W'(i);
                found    = 1'b1;
            end
        if (!found)
            for (int i = 0; i < N; i++)
                if (oldest_i[i]) victim_o = WAY_W'(i);
    end

    // R2: one tag lives in at most one way of a set
    p_unique_tag_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));
endmodule

// File: rtl/cache_lru.sv
module cache_lru
    import cache_pkg::*;
#(
    parameter int N = WAYS,
    parameter int S = SETS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(S)-1:0]      rd_set_i,
    output logic [N-1:0]              oldest_o,
    input  logic                      touch_i,
    input  logic [$clog2(S)-1:0]      touch_set_i,
    input  logic [WAY_W-1:0]          touch_way_i
);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(N - 1);

    logic [AGE_W-1:0] age_q [S][N];

    for (genvar g = 0; g < N; g++) begin : g_old
        assign oldest_o[g] = (age_q[rd_set_i][g] == AGE_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < S; s++)
                for (int w = 0; w < N; w++)
                    age_q[s][w] <= AGE_W'(w);
        end else if (touch_i) begin
            for (int w = 0; w < N; w++) begin
                if (WAY_W'(w) == touch_way_i)
                    age_q[touch_set_i][w] <= '0;
                else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
                    age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
            end
        end
    end

    // R7: ages stay a permutation, so exactly one way is oldest
    p_single_oldest_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_o) == 1);
endmodule

// File: rtl/sa_cache.sv
module sa_cache
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    tag_entry_t        tag_q  [SETS][WAYS];
    logic [DATA_W-1:0] data_q [SETS][WAYS];

    cst_e              st_q;
    logic [ADDR_W-1:0] miss_addr_q;
    logic [WAY_W-1:0]  victim_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    logic [IDX_W-1:0]       req_idx, fill_idx;
    tag_entry_t [WAYS-1:0]  set_ways;
    logic [WAYS-1:0]        oldest;
    logic                   hit;
    logic [WAY_W-1:0]       hit_way, victim;
    logic                   take, fill;
    logic                   touch;
    logic [IDX_W-1:0]       touch_set;
    logic [WAY_W-1:0]       touch_way;

    assign req_idx  = idx_of(cpu_addr);
    assign fill_idx = idx_of(miss_addr_q);

    for (genvar g = 0; g < WAYS; g++) begin : g_rd
        assign set_ways[g] = tag_q[req_idx][g];
    end

    assign cpu_ready = (st_q == ST_IDLE);
    assign take      = cpu_ready && cpu_req;
    assign fill      = (st_q == ST_FILL) && mem_ack;

    assign touch     = (take && hit) || fill;
    assign touch_set = fill ? fill_idx : req_idx;
    assign touch_way = fill ? victim_q : hit_way;

    cache_way_match #(.N(WAYS)) u_match (
        .clk       (clk),
        .rst       (rst),
        .ways_i    (set_ways),
        .tag_i     (tag_of(cpu_addr)),
        .oldest_i  (oldest),
        .hit_o     (hit),
        .hit_way_o (hit_way),
        .victim_o  (victim)
    );

    cache_lru #(.N(WAYS), .S(SETS)) u_lru (
        .clk         (clk),
        .rst         (rst),
        .rd_set_i    (req_idx),
        .oldest_o    (oldest),
        .touch_i     (touch),
        .touch_set_i (touch_set),
        .touch_way_i (touch_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            miss_addr_q <= '0;
            victim_q    <= '0;
            rvalid_q    <= 1'b0;
            rdata_q     <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    tag_q[s][w].valid <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (take) begin
                    if (hit) begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= data_q[req_idx][hit_way];
                    end else begin
                        st_q        <= ST_FILL;
                        miss_addr_q <= cpu_addr;
                        victim_q    <= victim;
                    end
                end
                ST_FILL: if (mem_ack) begin
                    tag_q[fill_idx][victim_q] <= '{valid: 1'b1, tag: tag_of(miss_addr_q)};
                    rvalid_q <= 1'b1;
                    rdata_q  <= mem_rdata;
                    st_q     <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (fill) data_q[fill_idx][victim_q] <= mem_rdata;
    end

    assign cpu_rvalid = rvalid_q;
    assign cpu_rdata  = rdata_q;
    assign mem_req    = (st_q == ST_FILL);
    assign mem_addr   = miss_addr_q;

    // R4: fetch held steady until acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
    // R4: processor port stalled while fetching
    p_stall_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready);
    // R5: acknowledged word forwarded next cycle
    p_fwd_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> cpu_rvalid && cpu_ready && cpu_rdata == $past(mem_rdata));
    // R3: a response only follows a request or an acknowledge
    p_rsp_cause_r3: assert property (@(posedge clk) disable iff (rst)
        !(cpu_req && cpu_ready) && !(mem_req && mem_ack) |=> !cpu_rvalid);
endmodule

// File: tb/sa_cache_bench.sv
module sa_cache_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_ready, cpu_rvalid, mem_req;
    logic [31:0] cpu_rdata, mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int misses = 0;
    int stamp  = 0;
    bit done   = 0;

    int mtag   [256][4];
    bit mval   [256][4];
    int mstamp [256][4];

    always #10 clk = ~clk;

    sa_cache u_sa_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[17:2], ~a[31:18], 2'b01} ^ 32'h5A3C_96E1;
    endfunction

    task automatic chk(input string rq, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input int lat, input bit poke, output bit was_miss);
        int s, slot, t, vic, best;
        bit hit;
        s = int'(a[9:2]); t = int'(a[31:10]); hit = 0; slot = -1;
        for (int i = 0; i < 4; i++)
            if (mval[s][i] && mtag[s][i] == t) begin hit = 1; slot = i; end
        chk("R9 ready before request", cpu_ready == 1'b1, 32'(cpu_ready), 32'd1);
        cpu_req = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_req = 1'b0;
        if (hit) begin
            chk("R3 hit rvalid", cpu_rvalid == 1'b1, 32'(cpu_rvalid), 32'd1);
            chk("R3 hit data", cpu_rdata == word_of(a), cpu_rdata, word_of(a));
            chk("R3 no fetch on hit", mem_req == 1'b0, 32'(mem_req), 32'd0);
        end else begin
            chk("R4 fetch raised", mem_req == 1'b1 && cpu_ready == 1'b0 && cpu_rvalid == 1'b0,
                {29'd0, mem_req, cpu_ready, cpu_rvalid}, 32'd4);
            chk("R4 fetch address", mem_addr == a, mem_addr, a);
            for (int c = 0; c < lat; c++) begin
                if (poke) begin cpu_req = 1'b1; cpu_addr = a ^ 32'h0000_0C00; end
                @(negedge clk);
                cpu_req = 1'b0;
                chk(poke ? "R9 held during stall" : "R4 held during wait",
                    mem_req == 1'b1 && mem_addr == a && cpu_rvalid == 1'b0, mem_addr, a);
            end
            mem_ack = 1'b1; mem_rdata = word_of(mem_addr);
            @(negedge clk);
            mem_ack = 1'b0; mem_rdata = '0;
            chk("R5 fill response", cpu_rvalid == 1'b1 && cpu_ready == 1'b1 && mem_req == 1'b0,
                {29'd0, cpu_rvalid, cpu_ready, mem_req}, 32'd6);
            chk("R5 fill data", cpu_rdata == word_of(a), cpu_rdata, word_of(a));
            vic = -1; best = 0;
            for (int i = 0; i < 4; i++)
                if (vic < 0 && !mval[s][i]) vic = i;
            if (vic < 0) begin
                vic = 0; best = mstamp[s][0];
                for (int i = 1; i < 4; i++)
                    if (mstamp[s][i] < best) begin best = mstamp[s][i]; vic = i; end
            end
            slot = vic; mval[s][slot] = 1; mtag[s][slot] = t;
            misses++;
        end
        stamp++;
        mstamp[s][slot] = stamp;
        was_miss = !hit;
        @(negedge clk);
        chk("R9 no stray response", cpu_rvalid == 1'b0, 32'(cpu_rvalid), 32'd0);
    endtask

    function automatic logic [31:0] at(input int tag, input int set);
        return (32'(tag) << 10) | (32'(set) << 2);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit m;
        int base;
        for (int s = 0; s < 256; s++)
            for (int w = 0; w < 4; w++) begin mval[s][w] = 0; mtag[s][w] = 0; mstamp[s][w] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ready", cpu_ready == 1'b1, 32'(cpu_ready), 32'd1);
        chk("R1 reset idle outputs", cpu_rvalid == 1'b0 && mem_req == 1'b0,
            {30'd0, cpu_rvalid, mem_req}, 32'd0);

        // R8: block sequence 0,8,0,6,8
        base = misses;
        access(32'd0,  1, 0, m); chk("R8 first 0 misses", m == 1, 32'(m), 32'd1);
        access(32'd32, 0, 0, m); chk("R8 first 8 misses", m == 1, 32'(m), 32'd1);
        access(32'd0,  1, 0, m); chk("R8 second 0 hits",  m == 0, 32'(m), 32'd0);
        access(32'd24, 2, 0, m); chk("R8 first 6 misses", m == 1, 32'(m), 32'd1);
        access(32'd32, 1, 0, m); chk("R8 second 8 hits",  m == 0, 32'(m), 32'd0);
        chk("R8 miss total", misses - base == 3, 32'(misses - base), 32'd3);

        // R2: byte offset ignored, same index different tag separate
        access(32'd3,  1, 0, m); chk("R2 offset bits ignored", m == 0, 32'(m), 32'd0);
        access(at(1, 0), 3, 0, m); chk("R2 new tag same index misses", m == 1, 32'(m), 32'd1);
        access(32'd0,  1, 0, m); chk("R2 first tag still resident", m == 0, 32'(m), 32'd0);

        // R6: four tags fill set 5 with no eviction
        for (int t = 0; t < 4; t++) begin
            access(at(t + 16, 5), t, 0, m); chk("R6 cold fill misses", m == 1, 32'(m), 32'd1);
        end
        for (int t = 0; t < 4; t++) begin
            access(at(t + 16, 5), 0, 0, m); chk("R6 all four resident", m == 0, 32'(m), 32'd0);
        end

        // R7: recency now 16(old) 17 18 19; touch 16 so 17 is oldest
        access(at(16, 5), 0, 0, m); chk("R7 refresh hit", m == 0, 32'(m), 32'd0);
        access(at(20, 5), 2, 0, m); chk("R7 fifth tag misses", m == 1, 32'(m), 32'd1);
        access(at(16, 5), 0, 0, m); chk("R7 refreshed way kept", m == 0, 32'(m), 32'd0);
        access(at(18, 5), 0, 0, m); chk("R7 newer way kept", m == 0, 32'(m), 32'd0);
        access(at(17, 5), 1, 0, m); chk("R7 LRU way evicted", m == 1, 32'(m), 32'd1);
        access(at(19, 5), 1, 0, m); chk("R7 next LRU evicted by refill", m == 1, 32'(m), 32'd1);

        // R9: requests during a stall ignored
        access(at(40, 77), 4, 1, m); chk("R9 stalled miss counted once", m == 1, 32'(m), 32'd1);
        access(at(40, 77) ^ 32'h0000_0C00, 1, 0, m);
        chk("R9 poked address never fetched", m == 1, 32'(m), 32'd1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule